// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block is a six-entry first-in first-out buffer of instruction bytes. It sits between a 16-bit code fetch port and a decoder that takes one byte at a time. The block holds a code pointer and asks for a word at that pointer whenever at least two byte slots are free. When the pointer is odd, it keeps only the upper byte of the returned word and steps the pointer by one. When the pointer is even, it keeps both bytes, lower byte first, and steps by two. Fetching runs alongside consumption, so the decoder is never held up while a byte is present.

Each clock, the consumer may take the head byte. A side input tells the block whether that byte opens a new instruction. One clock after each operation, the block reports what it did on a two-bit status output. A flush loads a new code pointer, discards every held byte, and drops any fetch word acknowledged in the same clock. The next fetch then starts from the new pointer.

Top module: `pfq_top`

## Requirements
- R1: After reset the queue is empty (`byte_valid_o` = 0), the status is 00, the fetch request is high, and the fetch address equals parameter `RESET_PTR`.
- R2: Bytes leave the queue in the order they arrived, so the consumer sees the bytes at consecutive code addresses starting from the last loaded pointer.
- R3: `fetch_req_o` is high exactly when at most DEPTH-2 (default 4) bytes are held. The queue never holds more than DEPTH bytes.
- R4: On an accepted fetch at an odd address, only `fetch_data_i[15:8]` is queued and the pointer advances by 1. At an even address, `fetch_data_i[7:0]` is queued first, then `fetch_data_i[15:8]`, and the pointer advances by 2.
- R5: A take of a held byte reports status 01 in the next clock when `take_first_i` is 1, and status 11 when it is 0.
- R6: Status is 00 in the clock after any clock with no flush and no effective take. A take while the queue is empty has no effect and reports 00.
- R7: A flush empties the queue, reports status 10 in the next clock, and loads `flush_ptr_i` as the fetch address. A fetch acknowledge or a take in the flush clock is ignored.
- R8: An enqueue and a dequeue in the same clock are both performed, and the held count changes by their net amount.
- R9: While a request is pending without an acknowledge or a flush, the fetch address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Discard the queue and reload the pointer |
| flush_ptr_i | input | AW | New code pointer loaded on flush |
| fetch_req_o | output | 1 | Fetch request, at least two slots free |
| fetch_addr_o | output | AW | Code pointer of the requested word |
| fetch_ack_i | input | 1 | Fetch word returned this clock |
| fetch_data_i | input | 16 | Returned word, even byte in the low lane |
| take_i | input | 1 | Consumer takes the head byte |
| take_first_i | input | 1 | The byte taken opens a new instruction |
| byte_o | output | 8 | Head byte |
| byte_valid_o | output | 1 | At least one byte held |
| qstat_o | output | 2 | Status of the previous clock's operation |

## Verification
A wrong fill count shows up within one clock: the fetch request rises or falls at the wrong occupancy, or `byte_valid_o` drops while bytes should still be held. A read or write pointer that wraps wrongly shows up as an out-of-order byte on the first take after the wrap, which is at most six takes after a fill. A status-register fault appears on the clock right after the take or flush that caused it. A pointer-step fault changes the fetch address on the first clock after the acknowledge.

// File: rtl/pfq_pkg.sv
// Shared types for the prefetch byte queue.
// Assumes a two-bit status code that the decoder side decodes.
package pfq_pkg;
    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;
endpackage

// File: rtl/pfq_fetch.sv
// Fetch pointer and request logic.
// Raises a request while at most DEPTH-2 bytes are held, and steps the
// pointer by 1 (odd) or 2 (even) on each accepted word.
// Assumes the acknowledge and the data arrive in the same clock.
module pfq_fetch #(
    parameter int              DEPTH     = 6,
    parameter int              AW        = 20,
    parameter logic [AW-1:0]   RESET_PTR = '0,
    localparam int             CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_ptr_i,
    input  logic [CW-1:0] fill_cnt,
    input  logic          fetch_ack_i,
    output logic          fetch_req_o,
    output logic [AW-1:0] fetch_addr_o,
    output logic [1:0]    push_n_o,
    output logic          push_odd_o
);
    localparam int ROOM = DEPTH - 2;

    logic [AW-1:0] ptr_q;
    logic          accept;

    // Request when two slots are free; accept only outside a flush.
    always_comb begin
        fetch_req_o = (fill_cnt <= CW'(ROOM));
        accept      = fetch_req_o && fetch_ack_i && !flush_i;
        push_odd_o  = ptr_q[0];
        push_n_o    = accept ? (ptr_q[0] ? 2'd1 : 2'd2) : 2'd0;
    end

    // Pointer register: reload on flush, step on an accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= RESET_PTR;
        else if (flush_i)
            ptr_q <= flush_ptr_i;
        else if (accept)
            ptr_q <= ptr_q + AW'(push_n_o);
    end

    assign fetch_addr_o = ptr_q;
endmodule

// File: rtl/pfq_store.sv
// Circular byte store with a write port of 0, 1 or 2 bytes a clock and
// a one-byte read port. A flush clears the count and the pointers.
// Assumes the writer never pushes more than the free space.
module pfq_store #(
    parameter int  DEPTH = 6,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [1:0]    push_n_i,
    input  logic          push_odd_i,
    input  logic [15:0]   word_i,
    input  logic          pop_i,
    output logic [7:0]    head_o,
    output logic [CW-1:0] fill_cnt_o
);
    logic [7:0]    slot_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q, wr_nx;
    logic [CW-1:0] cnt_q;
    logic [7:0]    byte0, byte1;

    // Advance a slot index by n with wrap at DEPTH.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p, input int n);
        int s;
        s = int'(p) + n;
        if (s >= DEPTH) s = s - DEPTH;
        return PW'(s);
    endfunction

    // Lane select: odd pointer keeps the upper lane only.
    always_comb begin
        byte0 = push_odd_i ? word_i[15:8] : word_i[7:0];
        byte1 = word_i[15:8];
        wr_nx = bump(wr_q, 1);
    end

    // Slot writes for the first and second queued byte.
    always_ff @(posedge clk) begin
        for (int g = 0; g < DEPTH; g++) begin
            if (push_n_i != 2'd0 && wr_q == PW'(g))
                slot_q[g] <= byte0;
            else if (push_n_i == 2'd2 && wr_nx == PW'(g))
                slot_q[g] <= byte1;
        end
    end

    // Pointers and occupancy, updated by the net change of the clock.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= bump(wr_q, int'(push_n_i));
            if (pop_i) rd_q <= bump(rd_q, 1);
            cnt_q <= cnt_q + CW'(push_n_i) - CW'(pop_i);
        end
    end

    assign head_o     = slot_q[rd_q];
    assign fill_cnt_o = cnt_q;
endmodule

// File: rtl/pfq_status.sv
// Registered queue status, shown one clock after the operation.
// Assumes flush has priority over a take in the same clock.
module pfq_status
    import pfq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush_i,
    input  logic       pop_i,
    input  logic       first_i,
    output logic [1:0] qstat_o
);
    qstat_e stat_q;

    // Encode the operation of this clock for the next one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= QS_IDLE;
        else if (flush_i)
            stat_q <= QS_FLUSH;
        else if (pop_i)
            stat_q <= first_i ? QS_FIRST : QS_NEXT;
        else
            stat_q <= QS_IDLE;
    end

    assign qstat_o = stat_q;
endmodule

// File: rtl/pfq_top.sv
// Prefetch byte queue top: joins the fetch pointer, the byte store and
// the status register. Assumes a consumer that takes at most one byte
// a clock and a fetch port that answers with a word on acknowledge.
module pfq_top #(
    parameter int            DEPTH     = 6,
    parameter int            AW        = 20,
    parameter logic [AW-1:0] RESET_PTR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_ptr_i,
    output logic          fetch_req_o,
    output logic [AW-1:0] fetch_addr_o,
    input  logic          fetch_ack_i,
    input  logic [15:0]   fetch_data_i,
    input  logic          take_i,
    input  logic          take_first_i,
    output logic [7:0]    byte_o,
    output logic          byte_valid_o,
    output logic [1:0]    qstat_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] fill_cnt;
    logic [1:0]    push_n;
    logic          push_odd;
    logic          pop_ok;

    // Effective take: a byte is held and no flush is in progress.
    always_comb begin
        byte_valid_o = (fill_cnt != '0);
        pop_ok       = take_i && byte_valid_o && !flush_i;
    end

    pfq_fetch #(.DEPTH(DEPTH), .AW(AW), .RESET_PTR(RESET_PTR)) u_fetch (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_ptr_i(flush_ptr_i),
        .fill_cnt(fill_cnt), .fetch_ack_i(fetch_ack_i), .fetch_req_o(fetch_req_o),
        .fetch_addr_o(fetch_addr_o), .push_n_o(push_n), .push_odd_o(push_odd)
    );

    pfq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .push_n_i(push_n),
        .push_odd_i(push_odd), .word_i(fetch_data_i), .pop_i(pop_ok),
        .head_o(byte_o), .fill_cnt_o(fill_cnt)
    );

    pfq_status u_stat (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .pop_i(pop_ok),
        .first_i(take_first_i), .qstat_o(qstat_o)
    );
endmodule

// File: rtl/pfq_chk.sv
// Protocol and occupancy checks for pfq_top, attached by bind.
module pfq_chk #(
    parameter int  DEPTH = 6,
    parameter int  AW    = 20,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush_i,
    input logic [AW-1:0] flush_ptr_i,
    input logic          fetch_req_o,
    input logic [AW-1:0] fetch_addr_o,
    input logic          fetch_ack_i,
    input logic          take_i,
    input logic          take_first_i,
    input logic          byte_valid_o,
    input logic [1:0]    qstat_o,
    input logic [CW-1:0] fill_cnt
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH)); // R3
    AST_REQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> fill_cnt <= CW'(DEPTH - 2)); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && !fetch_ack_i && !flush_i) |=> ($stable(fetch_addr_o) && fetch_req_o)); // R9
    AST_ODD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fetch_ack_i && !flush_i && fetch_addr_o[0])
        |=> fetch_addr_o == $past(fetch_addr_o) + AW'(1)); // R4
    AST_EVEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fetch_ack_i && !flush_i && !fetch_addr_o[0])
        |=> fetch_addr_o == $past(fetch_addr_o) + AW'(2)); // R4
    AST_FLUSH_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (qstat_o == 2'b10 && !byte_valid_o)); // R7
    AST_FLUSH_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> fetch_addr_o == $past(flush_ptr_i)); // R7
    AST_TAKE_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && take_i && byte_valid_o)
        |=> qstat_o == ($past(take_first_i) ? 2'b01 : 2'b11)); // R5
    AST_IDLE_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !(take_i && byte_valid_o)) |=> qstat_o == 2'b00); // R6
endmodule

bind pfq_top pfq_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_ptr_i(flush_ptr_i),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .fetch_ack_i(fetch_ack_i), .take_i(take_i), .take_first_i(take_first_i),
    .byte_valid_o(byte_valid_o), .qstat_o(qstat_o), .fill_cnt(fill_cnt)
);

// File: tb/sim_pfq_top.sv
// Directed bench for pfq_top: a code memory model answers fetches and
// a reference count tracks the expected occupancy from the requirements.
module sim_pfq_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 6;
    localparam int AW         = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic [AW-1:0] flush_ptr_i = '0;
    logic          fetch_req_o;
    logic [AW-1:0] fetch_addr_o;
    logic          fetch_ack_i = 1'b0;
    logic [15:0]   fetch_data_i = '0;
    logic          take_i = 1'b0;
    logic          take_first_i = 1'b0;
    logic [7:0]    byte_o;
    logic          byte_valid_o;
    logic [1:0]    qstat_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    int            m_cnt = 0;
    logic [AW-1:0] m_ptr = '0;
    logic [AW-1:0] m_rd  = '0;
    logic [1:0]    m_q   = 2'b00;

    pfq_top #(.DEPTH(DEPTH), .AW(AW), .RESET_PTR('0)) u0 (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_ptr_i(flush_ptr_i),
        .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
        .fetch_ack_i(fetch_ack_i), .fetch_data_i(fetch_data_i),
        .take_i(take_i), .take_first_i(take_first_i), .byte_o(byte_o),
        .byte_valid_o(byte_valid_o), .qstat_o(qstat_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] code_at(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive inputs, check pre-edge outputs, step, check status.
    task automatic tick(input logic fl, input logic [AW-1:0] fp,
                        input logic tk, input logic fr, input logic ak,
                        input string addr_req);
        int  nin, nout;
        bit  req_now;
        flush_i      = fl;
        flush_ptr_i  = fp;
        take_i       = tk;
        take_first_i = fr;
        fetch_ack_i  = ak;
        fetch_data_i = {code_at(fetch_addr_o | AW'(1)), code_at(fetch_addr_o & ~AW'(1))};
        req_now = (m_cnt <= DEPTH - 2);
        chk(fetch_req_o == req_now, "R3 request", int'(fetch_req_o), int'(req_now));
        chk(byte_valid_o == (m_cnt != 0), "R8 valid", int'(byte_valid_o), int'(m_cnt != 0));
        chk(fetch_addr_o == m_ptr, addr_req, int'(fetch_addr_o), int'(m_ptr));
        if (tk && m_cnt != 0)
            chk(byte_o == code_at(m_rd), "R2 order", int'(byte_o), int'(code_at(m_rd)));
        @(posedge clk);
        @(negedge clk);
        if (fl) begin
            m_cnt = 0; m_ptr = fp; m_rd = fp; m_q = 2'b10;
        end else begin
            nin  = (ak && req_now) ? (m_ptr[0] ? 1 : 2) : 0;
            nout = (tk && m_cnt != 0) ? 1 : 0;
            m_cnt = m_cnt + nin - nout;
            m_ptr = m_ptr + AW'(nin);
            if (nout != 0) m_rd = m_rd + AW'(1);
            m_q = (nout != 0) ? (fr ? 2'b01 : 2'b11) : 2'b00;
        end
        chk(qstat_o == m_q, fl ? "R7 status" : ((m_q == 2'b00) ? "R6 status" : "R5 status"),
            int'(qstat_o), int'(m_q));
        flush_i = 0; take_i = 0; fetch_ack_i = 0;
    endtask

    task automatic t_reset;
        chk(byte_valid_o == 1'b0, "R1 empty", int'(byte_valid_o), 0);
        chk(qstat_o == 2'b00, "R1 status", int'(qstat_o), 0);
        chk(fetch_req_o == 1'b1, "R1 request", int'(fetch_req_o), 1);
        chk(fetch_addr_o == '0, "R1 pointer", int'(fetch_addr_o), 0);
    endtask

    task automatic t_fill_even;
        tick(1, 20'h00100, 0, 0, 0, "R7 pointer");
        for (int i = 0; i < 4; i++) tick(0, '0, 0, 0, 1, "R4 even step");
        chk(fetch_req_o == 1'b0, "R3 full no request", int'(fetch_req_o), 0);
        for (int i = 0; i < 7; i++) tick(0, '0, 1, (i == 0), 0, "R4 hold");
        chk(byte_valid_o == 1'b0, "R6 drained", int'(byte_valid_o), 0);
    endtask

    task automatic t_odd;
        tick(1, 20'h00201, 0, 0, 0, "R7 pointer");
        for (int i = 0; i < 3; i++) tick(0, '0, 0, 0, 1, "R4 odd/even step");
        chk(fetch_req_o == 1'b0, "R3 five held", int'(fetch_req_o), 0);
        tick(0, '0, 1, 1, 0, "R4 hold");
        chk(fetch_req_o == 1'b1, "R3 four held", int'(fetch_req_o), 1);
        for (int i = 0; i < 5; i++) tick(0, '0, 1, (i == 2), 0, "R4 hold");
    endtask

    task automatic t_stall;
        tick(1, 20'h00400, 0, 0, 0, "R7 pointer");
        for (int i = 0; i < 4; i++) tick(0, '0, 0, 0, 0, "R9 held address");
        tick(0, '0, 1, 1, 0, "R9 held address");
    endtask

    task automatic t_overlap;
        tick(1, 20'h00503, 0, 0, 0, "R7 pointer");
        for (int i = 0; i < 30; i++) tick(0, '0, (i > 0), (i % 3 == 1), 1, "R8 overlap");
        for (int i = 0; i < 8; i++) tick(0, '0, 1, 0, 0, "R8 drain");
    endtask

    task automatic t_flush_mid;
        tick(1, 20'h00600, 0, 0, 0, "R7 pointer");
        tick(0, '0, 0, 0, 1, "R4 step");
        tick(0, '0, 0, 0, 1, "R4 step");
        tick(1, 20'h00777, 1, 1, 1, "R7 pointer");
        chk(byte_valid_o == 1'b0, "R7 emptied", int'(byte_valid_o), 0);
        chk(fetch_addr_o == 20'h00777, "R7 new pointer", int'(fetch_addr_o), 'h777);
        tick(0, '0, 0, 0, 1, "R4 odd step");
        tick(0, '0, 1, 1, 0, "R7 refill");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_even();
        t_odd();
        t_stall();
        t_overlap();
        t_flush_mid();
        finish_run();
    end
endmodule